// File: doc/BRIEF.md
# E3 Serial Payload Input (Frame-Slave)

This block is the transmit-side entry point for payload bits of an E3 framer when the framer runs on the local transmit clock and takes its frame timing from the system side. The terminal equipment sends a single-cycle frame-reference pulse to mark where each frame begins. An internal bit counter locks to that pulse. From the counter, the block tells the equipment which bit periods belong to framing overhead. It then samples the serial data input in every other bit period and presents each sampled bit with its payload index and a valid strobe.

A frame is 16 overhead bit periods followed by 4240 payload bit periods. Overhead is sent most significant bit first and begins with bit 7 of the first alignment byte. The framer produces the two alignment bytes itself, so anything the equipment drives during the overhead window is dropped. If no reference pulse arrives, the counter keeps running and wraps at the frame length. If a pulse arrives at any other point, the counter realigns to it and raises a flag for one cycle. The block only works when a 2-bit timing-select field reads `01` and the interface-select input is low (serial).

Top module: `e3_payload_rx`

## Requirements
- R1: After synchronous reset, `ovh_ind`, `pay_valid` and `misalign` are low. `pay_valid` stays low until the first `frame_ref` pulse has been accepted.
- R2: When `frame_ref` is high at a rising edge, the bit period that starts at that edge is bit 0 of the frame (counter position 0).
- R3: `ovh_ind` is high for exactly the 16 consecutive bit periods at counter positions 0 to 15. It is low at every other position.
- R4: A bit sampled while `ovh_ind` is high is never presented as payload. No `pay_valid` follows an overhead bit period.
- R5: For a bit period at counter position p ≥ 16, the next cycle shows `pay_valid` high, `pay_idx` = p − 16 (range 0 to 4239), and `pay_bit` equal to the `ser_in` value sampled in period p.
- R6: With no reference pulse, the counter advances one position per cycle and wraps from position 4255 to position 0 (4256 bit periods per frame).
- R7: A `frame_ref` pulse in the period at position 4255 (the expected wrap point) leaves the sequence unchanged and does not raise `misalign`.
- R8: A `frame_ref` pulse in any other period while locked realigns the counter to position 0 at once. `misalign` is then high for exactly the following cycle. The first pulse after reset or after a mode change raises no `misalign`.
- R9: The block is active only when `timing_sel` = 2'b01 and `serial_sel_n` = 0. In any other setting:
  - `ovh_ind`, `pay_valid` and `misalign` stay low.
  - `frame_ref` is ignored.
  - The lock is dropped, so a new pulse is needed after the block returns to the active setting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local transmit bit clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| serial_sel_n | input | 1 | Low selects the serial interface |
| timing_sel | input | 2 | Timing reference select; 2'b01 = local timing, frame slave |
| frame_ref | input | 1 | Single-cycle frame boundary pulse from the system side |
| ser_in | input | 1 | Serial payload data from the system side |
| ovh_ind | output | 1 | High during the 16 overhead bit periods |
| pay_bit | output | 1 | Captured payload bit |
| pay_idx | output | 13 | Index of the captured payload bit within the frame |
| pay_valid | output | 1 | `pay_bit` and `pay_idx` are valid |
| misalign | output | 1 | One-cycle flag for a reference pulse off the wrap point |

## Verification
The main function is exercised in several ways:
- One pulse followed by more than a full frame with no further pulse. This separates correct wrap length and index numbering from off-by-one counters.
- Serial data held high during overhead. This shows whether overhead bits leak into the payload.
- A pulse exactly at the wrap point, then pulses in mid-payload and inside the overhead window. These separate seamless re-reference from realignment and check that the flag fires only in the second case.
- Every inactive mode combination, then a return to the active mode without a pulse. This shows that the outputs are gated and that the lock really drops.

// File: rtl/e3_payload_rx.sv
module e3_payload_rx #(
  parameter int OVH_BITS = 16,
  parameter int PAY_BITS = 4240,
  localparam int FRAME_LEN = OVH_BITS + PAY_BITS,
  localparam int CNT_W = $clog2(FRAME_LEN),
  localparam int IDX_W = $clog2(PAY_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             serial_sel_n,
  input  logic [1:0]       timing_sel,
  input  logic             frame_ref,
  input  logic             ser_in,
  output logic             ovh_ind,
  output logic             pay_bit,
  output logic [IDX_W-1:0] pay_idx,
  output logic             pay_valid,
  output logic             misalign
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] OVH_END = CNT_W'(OVH_BITS);

  logic [CNT_W-1:0] cnt;
  logic             locked;
  logic             mode_ok;
  logic             in_ovh;
  logic             ref_take;

  assign mode_ok  = (timing_sel == 2'b01) && !serial_sel_n;
  assign in_ovh   = cnt < OVH_END;
  assign ovh_ind  = mode_ok && locked && in_ovh;
  assign ref_take = mode_ok && frame_ref;

  always_ff @(posedge clk) begin
    if (rst || !mode_ok) begin
      cnt    <= '0;
      locked <= 1'b0;
    end else if (ref_take) begin
      cnt    <= '0;
      locked <= 1'b1;
    end else if (locked) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pay_valid <= 1'b0;
      pay_bit   <= 1'b0;
      pay_idx   <= '0;
      misalign  <= 1'b0;
    end else begin
      pay_valid <= mode_ok && locked && !in_ovh;
      misalign  <= ref_take && locked && (cnt != LAST);
      if (mode_ok && locked && !in_ovh) begin
        pay_bit <= ser_in;
        pay_idx <= IDX_W'(cnt - OVH_END);
      end
    end
  end

  // R4
  ovh_no_capture_chk: assert property (@(posedge clk) disable iff (rst)
    ovh_ind |=> !pay_valid);

  // R9
  mode_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !mode_ok |=> !pay_valid && !misalign && !ovh_ind);

  // R8
  misalign_cause_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> $past(frame_ref));

  // R3
  ovh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ovh_ind && mode_ok && !frame_ref && (cnt != OVH_END - 1'b1) |=> ovh_ind);

  // R5
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    pay_valid && $past(pay_valid) && (pay_idx != '0) |-> pay_idx == $past(pay_idx) + 1'b1);

endmodule

// File: tb/e3_payload_rx_bench.sv
module e3_payload_rx_bench;
  localparam int FLEN = 4256;
  localparam int LASTP = FLEN - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic serial_sel_n = 1'b0;
  logic [1:0] timing_sel = 2'b01;
  logic frame_ref = 1'b0;
  logic ser_in = 1'b0;
  logic ovh_ind, pay_bit, pay_valid, misalign;
  logic [12:0] pay_idx;

  int n_run = 0;
  int n_fail = 0;
  int m_c = 0;
  bit m_lk = 0;

  always #5 clk = ~clk;

  e3_payload_rx u_e3_payload_rx (
    .clk(clk), .rst(rst), .serial_sel_n(serial_sel_n), .timing_sel(timing_sel),
    .frame_ref(frame_ref), .ser_in(ser_in), .ovh_ind(ovh_ind), .pay_bit(pay_bit),
    .pay_idx(pay_idx), .pay_valid(pay_valid), .misalign(misalign));

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic tick(input logic fr, input logic d, input string tag);
    bit mode, ev, em;
    int ei;
    mode = (timing_sel == 2'b01) && !serial_sel_n;
    frame_ref = fr;
    ser_in = d;
    ev = mode && m_lk && (m_c >= 16);
    ei = m_c - 16;
    em = mode && fr && m_lk && (m_c != LASTP);
    if (!mode) begin m_lk = 0; m_c = 0; end
    else if (fr) begin m_lk = 1; m_c = 0; end
    else if (m_lk) m_c = (m_c == LASTP) ? 0 : m_c + 1;
    @(posedge clk);
    @(negedge clk);
    frame_ref = 1'b0;
    chk(tag, "pay_valid", int'(pay_valid), int'(ev));
    chk(tag, "misalign", int'(misalign), int'(em));
    chk(tag, "ovh_ind", int'(ovh_ind), int'(mode && m_lk && m_c < 16));
    if (ev) begin
      chk(tag, "pay_idx", int'(pay_idx), ei);
      chk(tag, "pay_bit", int'(pay_bit), int'(d));
    end
  endtask

  function automatic logic pat(input int c);
    return (c < 16) ? 1'b1 : logic'(((c * 37) >> 3) & 1);
  endfunction

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, pat(m_c), tag);
  endtask

  // R1: reset state and no payload before the first pulse
  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "ovh_ind", int'(ovh_ind), 0);
    chk("R1", "pay_valid", int'(pay_valid), 0);
    chk("R1", "misalign", int'(misalign), 0);
    rst = 1'b0;
    m_lk = 0; m_c = 0;
    run(40, "R1");
  endtask

  // R2 R3 R4 R5 R6: align, one full frame, free-run wrap
  task automatic t_align_wrap;
    tick(1'b1, 1'b0, "R2");
    run(FLEN + 40, "R6");
  endtask

  // R7: pulse exactly at the wrap point
  task automatic t_on_time;
    while (m_c != LASTP) tick(1'b0, pat(m_c), "R7");
    tick(1'b1, pat(m_c), "R7");
    run(30, "R7");
  endtask

  // R8: pulses in mid-payload and inside overhead
  task automatic t_early;
    while (m_c != 100) tick(1'b0, pat(m_c), "R8");
    tick(1'b1, pat(m_c), "R8");
    run(5, "R8");
    tick(1'b1, 1'b1, "R8");
    run(40, "R8");
  endtask

  // R9: inactive modes, then return without and with a pulse
  task automatic t_mode;
    timing_sel = 2'b10;
    tick(1'b1, 1'b1, "R9"); run(10, "R9");
    timing_sel = 2'b00;
    tick(1'b1, 1'b1, "R9"); run(5, "R9");
    timing_sel = 2'b11;
    tick(1'b1, 1'b1, "R9"); run(5, "R9");
    timing_sel = 2'b01; serial_sel_n = 1'b1;
    tick(1'b1, 1'b1, "R9"); run(10, "R9");
    serial_sel_n = 1'b0;
    run(30, "R9");
    tick(1'b1, 1'b0, "R9");
    run(60, "R9");
  endtask

  task automatic finish_up;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_align_wrap();
    t_on_time();
    t_early();
    t_mode();
    finish_up();
  end
endmodule